// File: doc/BRIEF.md
# Lock-gated PWM timer

A single-channel pulse-width modulator driven through four word-addressed registers. A prescaler divides the core clock into ticks. A period counter runs on those ticks, either as a sawtooth (left-aligned) or as a triangle (center-aligned). The output asserts while the counter is inside the duty window, and the output level is flipped when the inverted polarity is selected.

Software writes period, duty and polarity into pending copies. The running waveform uses a separate committed set. The pending set moves into the committed set only at a period boundary, and all three settings move together. A lock flag in the control register blocks this move. Software sets the lock, rewrites any mix of period, duty and polarity, and then clears the lock. The new waveform then starts cleanly at the next boundary, with no mixed period.

Top module: `pwm_lock_gen`

## Requirements
- R1: After reset, every register reads 0 and pwm_o is low.
- R2: Word index 0 is duty, 1 is period, 2 is the counter (read-only, writes ignored), 3 is control. Duty and period keep their low CNT_W bits. Control bits are: bit 0 run, bit 1 invert, bit 3 output enable, bit 5 center mode, bit 6 lock, bit 8 low-power flag. All other control bits read 0.
- R3: While running, the counter advances exactly once every PRESCALE clocks.
- R4: In left-aligned mode with period P and duty D < P, the output is active for D*PRESCALE clocks out of every P*PRESCALE clocks.
- R5: In center-aligned mode, the counter rises 0..P-1 and then falls P-1..0, so one period is 2*P ticks. The output is active for 2*D ticks, centred on the top of the count.
- R6: Duty 0 keeps the output inactive. Duty at or above the period keeps it active.
- R7: With the lock clear, pending period, duty and polarity are committed at the next period boundary, never mid-period. While the timer is stopped, they are committed at once.
- R8: While the lock is set, writes to period, duty and invert do not change the running waveform.
- R9: After the lock is cleared, the pending period, duty and polarity all take effect together from the next boundary.
- R10: Invert = 0 gives an active-high duty phase and a low idle level. Invert = 1 gives an active-low duty phase and a high idle level.
- R11: When run or output enable is 0, pwm_o holds the idle level of the committed polarity.
- R12: The counter register reads the current tick count, below the period while running, and 0 while stopped.
- R13: The low-power flag is stored and read back, and has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 2 | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The hardest case to reach from the ports is a locked update. A new period, duty and polarity are all pending while the old set keeps running, and none of them may leak out early. The stimulus starts a known waveform and sets the lock. It then rewrites all three settings and measures whole-period high counts that must still match the old setting. Finally it clears the lock and measures again, expecting the new period, duty and polarity together. The assertions cover the timing side: committed values change only at a boundary, and never while the lock is held.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

  localparam int unsigned REG_AW = 2;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [REG_AW-1:0] {
    IDX_DUTY   = 2'd0,
    IDX_PERIOD = 2'd1,
    IDX_COUNT  = 2'd2,
    IDX_CTRL   = 2'd3
  } reg_idx_e;

  localparam int unsigned BIT_RUN    = 0;
  localparam int unsigned BIT_INV    = 1;
  localparam int unsigned BIT_OEN    = 3;
  localparam int unsigned BIT_CENTER = 5;
  localparam int unsigned BIT_LOCK   = 6;
  localparam int unsigned BIT_LP     = 8;

  typedef struct packed {
    logic lp;
    logic lock;
    logic center;
    logic oen;
    logic inv;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/pwm_lock_regs.sv
module pwm_lock_regs
  import pwm_lock_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]   duty_o,
  output logic [CNT_W-1:0]   period_o,
  output ctrl_t              ctrl_o
);

  logic [CNT_W-1:0] duty_q, period_q;
  ctrl_t            ctrl_q;
  logic             wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= '0;
      period_q <= '0;
      ctrl_q   <= '0;
    end else if (wr) begin
      unique case (reg_idx_e'(addr_i))
        IDX_DUTY:   duty_q   <= wdata_i[CNT_W-1:0];
        IDX_PERIOD: period_q <= wdata_i[CNT_W-1:0];
        IDX_CTRL: begin
          ctrl_q.run    <= wdata_i[BIT_RUN];
          ctrl_q.inv    <= wdata_i[BIT_INV];
          ctrl_q.oen    <= wdata_i[BIT_OEN];
          ctrl_q.center <= wdata_i[BIT_CENTER];
          ctrl_q.lock   <= wdata_i[BIT_LOCK];
          ctrl_q.lp     <= wdata_i[BIT_LP];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_idx_e'(addr_i))
      IDX_DUTY:   rdata_o[CNT_W-1:0] = duty_q;
      IDX_PERIOD: rdata_o[CNT_W-1:0] = period_q;
      IDX_COUNT:  rdata_o[CNT_W-1:0] = cnt_i;
      IDX_CTRL: begin
        rdata_o[BIT_RUN]    = ctrl_q.run;
        rdata_o[BIT_INV]    = ctrl_q.inv;
        rdata_o[BIT_OEN]    = ctrl_q.oen;
        rdata_o[BIT_CENTER] = ctrl_q.center;
        rdata_o[BIT_LOCK]   = ctrl_q.lock;
        rdata_o[BIT_LP]     = ctrl_q.lp;
      end
      default: ;
    endcase
  end

  assign duty_o   = duty_q;
  assign period_o = period_q;
  assign ctrl_o   = ctrl_q;

endmodule

// File: rtl/pwm_lock_tick.sv
module pwm_lock_tick #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign tick_o = run_i;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             pre_q <= '0;
        else if (!run_i)         pre_q <= '0;
        else if (pre_q == LAST)  pre_q <= '0;
        else                     pre_q <= pre_q + 1'b1;
      end
      assign tick_o = run_i & (pre_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/pwm_lock_counter.sv
module pwm_lock_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bnd_o
);

  logic [CNT_W-1:0] cnt_q, per_eff;
  logic             down_q, at_top;

  // period 0 behaves as period 1
  assign per_eff = (period_i == '0) ? CNT_W'(1) : period_i;
  assign at_top  = (cnt_q >= per_eff - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      if (!center_i) begin
        down_q <= 1'b0;
        cnt_q  <= at_top ? '0 : cnt_q + 1'b1;
      end else if (!down_q) begin
        if (at_top) down_q <= 1'b1;
        else        cnt_q  <= cnt_q + 1'b1;
      end else begin
        if (cnt_q == '0) down_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign bnd_o = run_i & tick_i & (center_i ? (down_q & (cnt_q == '0)) : at_top);
  assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_lock_wave.sv
module pwm_lock_wave #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             oen_i,
  input  logic             lock_i,
  input  logic             center_i,
  input  logic             bnd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] pend_duty_i,
  input  logic [CNT_W-1:0] pend_period_i,
  input  logic             pend_inv_i,
  output logic [CNT_W-1:0] act_duty_o,
  output logic [CNT_W-1:0] act_period_o,
  output logic             act_inv_o,
  output logic             pwm_o
);

  logic [CNT_W-1:0] duty_q, period_q, per_eff;
  logic             inv_q, hit, pwm_q, commit;

  // stopped timer tracks pending set; running one swaps only at an unlocked boundary
  assign commit = !run_i || (bnd_i && !lock_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= '0;
      period_q <= '0;
      inv_q    <= 1'b0;
    end else if (commit) begin
      duty_q   <= pend_duty_i;
      period_q <= pend_period_i;
      inv_q    <= pend_inv_i;
    end
  end

  assign per_eff = (period_q == '0) ? CNT_W'(1) : period_q;

  always_comb begin
    if (duty_q >= per_eff) hit = 1'b1;
    else if (center_i)     hit = (cnt_i >= per_eff - duty_q);
    else                   hit = (cnt_i < duty_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pwm_q <= 1'b0;
    else if (run_i && oen_i)  pwm_q <= hit ^ inv_q;
    else                      pwm_q <= inv_q;
  end

  assign act_duty_o   = duty_q;
  assign act_period_o = period_q;
  assign act_inv_o    = inv_q;
  assign pwm_o        = pwm_q;

endmodule

// File: rtl/pwm_lock_gen.sv
module pwm_lock_gen
  import pwm_lock_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRESCALE = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        pwm_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] pend_duty, pend_period, cnt, act_duty, act_period;
  logic             act_inv, tick, bnd, run, oen, lock;

  assign run  = ctrl.run;
  assign oen  = ctrl.oen;
  assign lock = ctrl.lock;

  pwm_lock_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cnt_i    (cnt),
    .rdata_o,
    .duty_o   (pend_duty),
    .period_o (pend_period),
    .ctrl_o   (ctrl)
  );

  pwm_lock_tick #(.PRESCALE(PRESCALE)) i_tick (
    .clk_i, .rst_ni,
    .run_i  (run),
    .tick_o (tick)
  );

  pwm_lock_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .run_i    (run),
    .tick_i   (tick),
    .center_i (ctrl.center),
    .period_i (act_period),
    .cnt_o    (cnt),
    .bnd_o    (bnd)
  );

  pwm_lock_wave #(.CNT_W(CNT_W)) i_wave (
    .clk_i, .rst_ni,
    .run_i         (run),
    .oen_i         (oen),
    .lock_i        (lock),
    .center_i      (ctrl.center),
    .bnd_i         (bnd),
    .cnt_i         (cnt),
    .pend_duty_i   (pend_duty),
    .pend_period_i (pend_period),
    .pend_inv_i    (ctrl.inv),
    .act_duty_o    (act_duty),
    .act_period_o  (act_period),
    .act_inv_o     (act_inv),
    .pwm_o
  );

endmodule

// File: rtl/pwm_lock_chk.sv
module pwm_lock_chk #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRESCALE = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             bnd_i,
  input logic             run_i,
  input logic             oen_i,
  input logic             lock_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] act_duty_i,
  input logic [CNT_W-1:0] act_period_i,
  input logic             act_inv_i,
  input logic             pwm_i
);

  logic [2*CNT_W:0] act_set;
  assign act_set = {act_duty_i, act_period_i, act_inv_i};

  generate
    if (PRESCALE > 1) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> !tick_i);
    end
  endgenerate

  // R12
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i < ((act_period_i == '0) ? CNT_W'(1) : act_period_i)));

  // R12
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_i == '0));

  // R7
  commit_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(act_set)) |-> $past(bnd_i));

  // R8
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && lock_i) |=> $stable(act_set));

  // R11
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && oen_i) |=> (pwm_i == $past(act_inv_i)));

  // R6
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && oen_i && act_duty_i == '0) |=> (pwm_i == $past(act_inv_i)));

endmodule

bind pwm_lock_gen pwm_lock_chk #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick),
  .bnd_i        (bnd),
  .run_i        (run),
  .oen_i        (oen),
  .lock_i       (lock),
  .cnt_i        (cnt),
  .act_duty_i   (act_duty),
  .act_period_i (act_period),
  .act_inv_i    (act_inv),
  .pwm_i        (pwm_o)
);

// File: tb/test_pwm_lock_gen.sv
module test_pwm_lock_gen;

  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pwm_o;

  int checks = 0, errors = 0;

  typedef struct {
    int    window;
    int    exp_high;
    string req;
  } item_t;

  item_t sb_q[$];
  event  mon_done;

  always #4 clk = ~clk;

  pwm_lock_gen #(.CNT_W(16), .PRESCALE(PRE)) i_pwm_lock_gen (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .pwm_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 2'(idx); wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    addr_i = 2'(idx);
    #1;
    d = rdata_o;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expect_high(input int window, input int exp_high, input string req);
    item_t it;
    it.window = window; it.exp_high = exp_high; it.req = req;
    sb_q.push_back(it);
    @(mon_done);
  endtask

  // monitor: counts active cycles over each queued window
  initial begin
    forever begin
      item_t it;
      int hi;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      hi = 0;
      for (int i = 0; i < it.window; i++) begin
        @(negedge clk);
        if (pwm_o) hi++;
      end
      check(hi == it.exp_high, it.req, hi, it.exp_high);
      ->mon_done;
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, c1, c2;
    wait_clk(3);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(i, d);
      check(d == 0, "R1", int'(d), 0);
    end
    check(pwm_o == 1'b0, "R1", int'(pwm_o), 0);
    rst_ni = 1'b1;
    wait_clk(2);

    // R2 field widths, read-only counter, control bits
    wr(0, 32'hFFFF_1234); rd(0, d);
    check(d == 32'h1234, "R2", int'(d), 32'h1234);
    wr(2, 32'h55); rd(2, d);
    check(d == 0, "R2", int'(d), 0);
    wr(3, 32'hFFFF_FFFF); rd(3, d);
    check(d == 32'h16B, "R2", int'(d), 32'h16B);
    wr(3, 32'h0);

    // R10 R11 stopped timer idles at the selected level
    wr(3, 32'h2); wait_clk(2);
    check(pwm_o == 1'b1, "R10", int'(pwm_o), 1);
    wr(3, 32'h0); wait_clk(2);
    check(pwm_o == 1'b0, "R11", int'(pwm_o), 0);

    // R4 left-aligned, P=10 D=3
    wr(1, 10); wr(0, 3); wr(3, 32'h9);
    wait_clk(90);
    expect_high(120, 36, "R4");

    // R3 R12 counter steps once per PRESCALE clocks
    rd(2, c1); wait_clk(PRE); rd(2, c2);
    check(c2 == (c1 + 1) % 10, "R3", int'(c2), int'((c1 + 1) % 10));
    check(c1 < 10, "R12", int'(c1), 9);

    // R13 low-power flag stored, no effect on waveform
    wr(3, 32'h109); rd(3, d);
    check(d == 32'h109, "R13", int'(d), 32'h109);
    expect_high(120, 36, "R13");
    wr(3, 32'h9);

    // R6 duty extremes
    wr(0, 0); wait_clk(90);
    expect_high(120, 0, "R6");
    wr(0, 10); wait_clk(90);
    expect_high(120, 120, "R6");
    wr(0, 15); wait_clk(90);
    expect_high(120, 120, "R6");

    // R10 inverted polarity
    wr(0, 3); wr(3, 32'hB); wait_clk(90);
    expect_high(120, 84, "R10");

    // R5 center-aligned, P=8 D=3: 64 clocks per period, 24 active
    wr(1, 8); wr(3, 32'h29); wait_clk(140);
    expect_high(128, 48, "R5");

    // back to left P=10 D=3 normal, then R8 locked rewrite
    wr(1, 10); wr(3, 32'h9); wait_clk(140);
    wr(3, 32'h49);
    wr(1, 6); wr(0, 5); wr(3, 32'h4B);
    wait_clk(90);
    expect_high(120, 36, "R8");
    rd(1, d);
    check(d == 6, "R8", int'(d), 6);

    // R9 release: P=6 D=5 inverted, 24 clocks/period, 4 active-high
    wr(3, 32'hB); wait_clk(90);
    expect_high(72, 12, "R9");

    // R7 unlocked update lands after a boundary
    wr(0, 2); wait_clk(60);
    expect_high(72, 48, "R7");

    // R11 output disabled while running
    wr(3, 32'h3); wait_clk(60);
    expect_high(72, 72, "R11");
    wr(3, 32'h1); wait_clk(60);
    expect_high(72, 0, "R11");

    // R12 stopped counter reads 0
    wr(3, 32'h8); wait_clk(3); rd(2, d);
    check(d == 0, "R12", int'(d), 0);
    check(pwm_o == 1'b0, "R11", int'(pwm_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule